// File: doc/BRIEF.md
# Incremental Step Program Sequencer

This block runs one page program operation on a two-bit-per-cell flash array. It loops over iterations. Each iteration has one program pulse and then a verify phase. During the verify phase the array compares the threshold of every cell against a selected level and returns one hit bit per cell. A cell that has reached its target is masked out of every later pulse. A cell that has not reached its target gets another pulse, and the pulse voltage code rises by one step each iteration. The operation ends early with a pass once every cell is masked. It ends with a fail, and sets a sticky error flag, if cells are still unmasked after the top voltage step.

A mode bit selects single or double verify at the start of each operation. In double verify, every level is read twice. The first read uses a pre-verify threshold slightly below the final one, and the second read uses the final threshold. A cell that clears the lower read but not the final one is given a bitline-bias flag, which softens its next pulse. Both modes drive the same three pump enables. Only the sequence of enables changes, and double verify holds the verify pump on for twice as long per iteration.

Control and status pins are plain levels and pulses. There is no streaming interface: targets and lengths are sampled once at start, and the array returns its per-cell hits on the same cycle it is read.

Top module: `ispp_seq`

## Requirements
- R1: After reset, all pump enables, `busy`, `done`, `pass`, `err`, `vstep`, `vsel`, `vsel_pre`, `inhibit` and `bias` are zero.
- R2: `tgt_level` holds two bits per cell, with cell i at bits [2i+1:2i]. Codes 1, 2 and 3 mean levels L1, L2 and L3. Code 0 means the cell stays erased, and its `inhibit` bit is set from the cycle after start.
- R3: A pulse phase holds `pgm_pump_en` and `inh_pump_en` high for `pulse_len` cycles, with 0 counted as 1. The verify pump is never on at the same time as the program pump.
- R4: In single verify, each verify phase reads `vsel` = 1, 2, 3 in that order. Each read lasts `vfy_len` cycles, with 0 counted as 1, and `vsel_pre` stays low. At the end of a read, only unmasked cells whose target equals `vsel` are judged. A hit sets the cell's `inhibit` bit, and that bit stays set for the rest of the operation.
- R5: In double verify, each level is read first with `vsel_pre` = 1 and then with `vsel_pre` = 0. The pre read sets a judged cell's `bias` bit to its hit. A final hit masks the cell and clears its bias. Verify-pump time per iteration doubles. In single verify `bias` stays zero.
- R6: `vstep` is 0 for the first pulse and rises by exactly 1 per iteration, up to at most 20. Code n means 14 V plus n times 0.25 V.
- R7: At the end of an iteration with every cell masked, `done` and `pass` rise. An all-erased page finishes with a pass and no pulse.
- R8: If cells are still unmasked after the iteration at step 20, the operation ends with `done` = 1, `pass` = 0 and `err` = 1. `err` stays set until reset.
- R9: The mode and both lengths are latched at start. A `start` or a `dv_mode` change while `busy` is high has no effect on the running operation.
- R10: `done` and `pass` hold their values after the end of an operation until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| dv_mode | input | 1 | 1 = double verify, 0 = single verify |
| pulse_len | input | LEN_W | Cycles per pulse phase |
| vfy_len | input | LEN_W | Cycles per verify read |
| tgt_level | input | 2*NCELL | Per-cell target level codes |
| vfy_hit | input | NCELL | Per-cell comparison result for the current read |
| pgm_pump_en | output | 1 | Program pump enable |
| inh_pump_en | output | 1 | Inhibit pump enable |
| vfy_pump_en | output | 1 | Verify pump enable |
| vstep | output | STEP_W | Pulse voltage step code |
| vsel | output | 2 | Level under verify (0 when not verifying) |
| vsel_pre | output | 1 | Current read uses the pre-verify threshold |
| inhibit | output | NCELL | Per-cell program mask |
| bias | output | NCELL | Per-cell bitline-bias flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished |
| pass | output | 1 | Finished with every cell masked |
| err | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with NCELL = 8 and LEN_W = 4, and keeps the step limit at 20. With these values the phase lengths can be drawn from 0 to 5, which covers the case where 0 is counted as one cycle, and each operation stays short. A cell model with gain 1 aiming at L3 cannot reach its target within 21 pulses, so the timeout path and the sticky error can be reached in a directed case. Random pages mix all four target codes and cell gains of 1 to 3. This drives the early-pass exit at many different iteration counts in both modes.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_VFY   = 2'd2,
    ST_CHK   = 2'd3
  } seq_st_e;

  localparam logic [1:0] LVL_TOP = 2'd3;
endpackage

// File: rtl/pss_timer.sv
module pss_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LEN_W-1:0] len,
  output logic             last
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] lim;

  assign lim  = (len == '0) ? '0 : len - LEN_W'(1);
  assign last = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run || last) cnt <= '0;
    else                cnt <= cnt + LEN_W'(1);
  end
endmodule

// File: rtl/pss_cell.sv
module pss_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic erased,
  input  logic match,
  input  logic judge_pre,
  input  logic judge_fin,
  input  logic hit,
  output logic inh,
  output logic bias
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh  <= 1'b0;
      bias <= 1'b0;
    end else if (load) begin
      inh  <= erased;
      bias <= 1'b0;
    end else if (match && !inh) begin
      if (judge_pre) bias <= hit;
      if (judge_fin && hit) begin
        inh  <= 1'b1;
        bias <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ispp_seq.sv
module ispp_seq
  import pss_pkg::*;
#(
  parameter int NCELL     = 16,
  parameter int LEN_W     = 8,
  parameter int STEP_LAST = 20,
  localparam int STEP_W   = $clog2(STEP_LAST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dv_mode,
  input  logic [LEN_W-1:0]   pulse_len,
  input  logic [LEN_W-1:0]   vfy_len,
  input  logic [2*NCELL-1:0] tgt_level,
  input  logic [NCELL-1:0]   vfy_hit,
  output logic               pgm_pump_en,
  output logic               inh_pump_en,
  output logic               vfy_pump_en,
  output logic [STEP_W-1:0]  vstep,
  output logic [1:0]         vsel,
  output logic               vsel_pre,
  output logic [NCELL-1:0]   inhibit,
  output logic [NCELL-1:0]   bias,
  output logic               busy,
  output logic               done,
  output logic               pass,
  output logic               err
);
  seq_st_e            st;
  logic               mode_q;
  logic [LEN_W-1:0]   plen_q, vlen_q;
  logic [2*NCELL-1:0] tgt_q;
  logic [STEP_W-1:0]  step_q;
  logic [1:0]         lvl_q;
  logic               pre_q;
  logic               done_q, pass_q, err_q;

  logic               tmr_run, tmr_last;
  logic [LEN_W-1:0]   tmr_len;
  logic               load, judge;
  logic [NCELL-1:0]   erased_in;
  logic               all_erased, all_inh;

  assign tmr_run = (st == ST_PULSE) || (st == ST_VFY);
  assign tmr_len = (st == ST_PULSE) ? plen_q : vlen_q;

  pss_timer #(.LEN_W(LEN_W)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (tmr_run),
    .len  (tmr_len),
    .last (tmr_last)
  );

  assign load  = (st == ST_IDLE) && start;
  assign judge = (st == ST_VFY) && tmr_last;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    assign erased_in[i] = (tgt_level[2*i +: 2] == 2'd0);
    pss_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .erased   (erased_in[i]),
      .match    (tgt_q[2*i +: 2] == lvl_q),
      .judge_pre(judge && pre_q),
      .judge_fin(judge && !pre_q),
      .hit      (vfy_hit[i]),
      .inh      (inhibit[i]),
      .bias     (bias[i])
    );
  end

  assign all_erased = &erased_in;
  assign all_inh    = &inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode_q <= 1'b0;
      plen_q <= '0;
      vlen_q <= '0;
      tgt_q  <= '0;
      step_q <= '0;
      lvl_q  <= 2'd0;
      pre_q  <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            mode_q <= dv_mode;
            plen_q <= pulse_len;
            vlen_q <= vfy_len;
            tgt_q  <= tgt_level;
            step_q <= '0;
            lvl_q  <= 2'd0;
            pre_q  <= 1'b0;
            done_q <= all_erased;
            pass_q <= all_erased;
            if (!all_erased) st <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          if (tmr_last) begin
            st    <= ST_VFY;
            lvl_q <= 2'd1;
            pre_q <= mode_q;
          end
        end
        ST_VFY: begin
          if (tmr_last) begin
            if (pre_q) begin
              pre_q <= 1'b0;
            end else if (lvl_q == LVL_TOP) begin
              st    <= ST_CHK;
              lvl_q <= 2'd0;
            end else begin
              lvl_q <= lvl_q + 2'd1;
              pre_q <= mode_q;
            end
          end
        end
        ST_CHK: begin
          if (all_inh) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            pass_q <= 1'b1;
          end else if (step_q == STEP_W'(STEP_LAST)) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            pass_q <= 1'b0;
            err_q  <= 1'b1;
          end else begin
            step_q <= step_q + STEP_W'(1);
            st     <= ST_PULSE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pgm_pump_en = (st == ST_PULSE);
  assign inh_pump_en = (st == ST_PULSE);
  assign vfy_pump_en = (st == ST_VFY);
  assign vstep       = step_q;
  assign vsel        = (st == ST_VFY) ? lvl_q : 2'd0;
  assign vsel_pre    = (st == ST_VFY) && pre_q;
  assign busy        = (st != ST_IDLE);
  assign done        = done_q;
  assign pass        = pass_q;
  assign err         = err_q;
endmodule

// File: rtl/ispp_seq_chk.sv
module ispp_seq_chk #(
  parameter int NCELL     = 16,
  parameter int STEP_LAST = 20,
  localparam int STEP_W   = $clog2(STEP_LAST + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pgm_pump_en,
  input logic              vfy_pump_en,
  input logic [STEP_W-1:0] vstep,
  input logic              vsel_pre,
  input logic [NCELL-1:0]  inhibit,
  input logic [NCELL-1:0]  bias,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              err,
  input logic              mode_q
);
  AST_PUMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_pump_en |-> !vfy_pump_en); // R3
  AST_INH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((inhibit & $past(inhibit)) == $past(inhibit))); // R4
  AST_BIAS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((bias & inhibit) == '0)); // R5
  AST_SV_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> (!vsel_pre && (bias == '0))); // R5
  AST_STEP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (vstep != $past(vstep)) |-> ((vstep == $past(vstep) + STEP_W'(1)) || (vstep == '0))); // R6
  AST_STEP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    vstep <= STEP_W'(STEP_LAST)); // R6
  AST_PASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (&inhibit)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) |-> err); // R8
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q)); // R9
endmodule

bind ispp_seq ispp_seq_chk #(.NCELL(NCELL), .STEP_LAST(STEP_LAST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pgm_pump_en(pgm_pump_en),
  .vfy_pump_en(vfy_pump_en),
  .vstep      (vstep),
  .vsel_pre   (vsel_pre),
  .inhibit    (inhibit),
  .bias       (bias),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .err        (err),
  .mode_q     (mode_q)
);

// File: tb/sim_ispp_seq.sv
module sim_ispp_seq;
  localparam int NC = 8;
  localparam int LW = 4;
  localparam int SL = 20;
  localparam int SW = $clog2(SL + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            dv_mode = 1'b0;
  logic [LW-1:0]   pulse_len = '0;
  logic [LW-1:0]   vfy_len = '0;
  logic [2*NC-1:0] tgt_level = '0;
  logic [NC-1:0]   vfy_hit = '0;
  logic pgm_pump_en, inh_pump_en, vfy_pump_en, vsel_pre, busy, done, pass, err;
  logic [SW-1:0]   vstep;
  logic [1:0]      vsel;
  logic [NC-1:0]   inhibit, bias;

  ispp_seq #(.NCELL(NC), .LEN_W(LW), .STEP_LAST(SL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dv_mode(dv_mode),
    .pulse_len(pulse_len), .vfy_len(vfy_len), .tgt_level(tgt_level),
    .vfy_hit(vfy_hit), .pgm_pump_en(pgm_pump_en), .inh_pump_en(inh_pump_en),
    .vfy_pump_en(vfy_pump_en), .vstep(vstep), .vsel(vsel), .vsel_pre(vsel_pre),
    .inhibit(inhibit), .bias(bias), .busy(busy), .done(done), .pass(pass), .err(err)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int vth0[NC];
  int vth[NC];
  int gain[NC];
  int tgt[NC];
  bit err_exp = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fthr(input int lvl, input bit pre);
    return 8 * lvl - (pre ? 1 : 0);
  endfunction

  function automatic void ref_model(input bit mode, output int np, output bit ok,
                                    output logic [NC-1:0] inh_o);
    int v[NC];
    bit b[NC];
    bit allm;
    inh_o = '0;
    for (int i = 0; i < NC; i++) begin
      v[i] = vth0[i]; b[i] = 1'b0; inh_o[i] = (tgt[i] == 0);
    end
    np = 0;
    ok = &inh_o;
    if (ok) return;
    for (int k = 0; k <= SL; k++) begin
      np++;
      for (int i = 0; i < NC; i++)
        if (!inh_o[i]) v[i] += b[i] ? 1 : gain[i];
      for (int l = 1; l <= 3; l++) begin
        if (mode)
          for (int i = 0; i < NC; i++)
            if (tgt[i] == l && !inh_o[i]) b[i] = (v[i] >= fthr(l, 1'b1));
        for (int i = 0; i < NC; i++)
          if (tgt[i] == l && !inh_o[i] && v[i] >= fthr(l, 1'b0)) begin
            inh_o[i] = 1'b1; b[i] = 1'b0;
          end
      end
      allm = &inh_o;
      if (allm) begin ok = 1'b1; return; end
    end
    ok = 1'b0;
  endfunction

  task automatic run_op(input string tag, input bit mode, input int plen,
                        input int vlen, input bit disturb);
    int np_exp, pulses, pgm_c, vfy_c, pre_c, cyc, pl, vl;
    bit ok_exp, prev_pgm, hung;
    logic [NC-1:0] inh_exp, er_mask;
    ref_model(mode, np_exp, ok_exp, inh_exp);
    if (!ok_exp) err_exp = 1'b1;
    pl = (plen == 0) ? 1 : plen;
    vl = (vlen == 0) ? 1 : vlen;
    er_mask = '0;
    for (int i = 0; i < NC; i++) begin
      vth[i] = vth0[i];
      tgt_level[2*i +: 2] = 2'(tgt[i]);
      er_mask[i] = (tgt[i] == 0);
    end
    pulses = 0; pgm_c = 0; vfy_c = 0; pre_c = 0; cyc = 0;
    prev_pgm = 1'b0; hung = 1'b0;
    @(negedge clk);
    dv_mode = mode; pulse_len = LW'(plen); vfy_len = LW'(vlen); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 erased masked"}, int'(inhibit & er_mask), int'(er_mask));
    forever begin
      if (pgm_pump_en && !prev_pgm) begin
        pulses++;
        for (int i = 0; i < NC; i++)
          if (!inhibit[i]) vth[i] += bias[i] ? 1 : gain[i];
      end
      prev_pgm = pgm_pump_en;
      if (pgm_pump_en) pgm_c++;
      if (vfy_pump_en) vfy_c++;
      if (vsel_pre) pre_c++;
      for (int i = 0; i < NC; i++)
        vfy_hit[i] = (vsel != 2'd0) && (vth[i] >= fthr(int'(vsel), vsel_pre));
      if (done) break;
      if (cyc > 30000) begin hung = 1'b1; break; end
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 5) begin start = 1'b1; dv_mode = ~mode; end
      if (disturb && cyc == 6) start = 1'b0;
    end
    chk({tag, " watchdog"}, int'(hung), 0);
    repeat (3) @(negedge clk);
    chk({tag, " R10 done held"}, int'(done), 1);
    chk({tag, " R7/R8 pass"}, int'(pass), int'(ok_exp));
    chk({tag, " R8 err"}, int'(err), int'(err_exp));
    chk({tag, " R6 pulse count"}, pulses, np_exp);
    chk({tag, " R6 final step"}, int'(vstep), (np_exp == 0) ? 0 : np_exp - 1);
    chk({tag, " R3 pulse cycles"}, pgm_c, np_exp * pl);
    chk({tag, " R4/R5 verify cycles"}, vfy_c, np_exp * 3 * (mode ? 2 : 1) * vl);
    chk({tag, " R5 pre cycles"}, pre_c, mode ? np_exp * 3 * vl : 0);
    chk({tag, " R4 mask"}, int'(inhibit), int'(inh_exp));
    chk({tag, " R9 idle"}, int'(busy), 0);
  endtask

  task automatic set_cells(input int g);
    for (int i = 0; i < NC; i++) begin
      tgt[i] = i % 4; vth0[i] = i % 3; gain[i] = g;
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done/pass/err", int'({done, pass, err}), 0);
    chk("R1 pumps", int'({pgm_pump_en, inh_pump_en, vfy_pump_en}), 0);
    chk("R1 step/sel", int'({vstep, vsel, vsel_pre}), 0);
    chk("R1 masks", int'({inhibit, bias}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NC; i++) begin tgt[i] = 0; vth0[i] = 0; gain[i] = 2; end
    run_op("erased", 1'b0, 2, 2, 1'b0);
    set_cells(2);
    run_op("sv_dir", 1'b0, 3, 2, 1'b0);
    run_op("dv_dir", 1'b1, 3, 2, 1'b0);
    set_cells(3);
    tgt[5] = 3; vth0[5] = 0; gain[5] = 1;
    run_op("timeout", 1'b0, 0, 0, 1'b0);
    set_cells(3);
    run_op("after_fail", 1'b1, 1, 1, 1'b0);
    run_op("disturb", 1'b1, 2, 1, 1'b1);
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < NC; i++) begin
        tgt[i] = $urandom_range(0, 3);
        vth0[i] = $urandom_range(0, 5);
        gain[i] = $urandom_range(1, 3);
      end
      run_op("rand", 1'($urandom_range(0, 1)), $urandom_range(0, 5),
             $urandom_range(0, 5), 1'b0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule